// File: doc/BRIEF.md
# Register-Mapped Serial Port Core

This block is a serial transmitter and receiver behind a bank of 32-bit word registers. Software writes one character at a time into a single-entry transmit holding register. The core moves that character into a shifter and sends it on an idle-high line: a low start bit, eight data bits with the least significant bit first, an optional odd parity bit and one high stop bit. Each bit lasts sixteen pulses of an oversample tick. The tick comes from a rate generator outside the block, and the core passes the stored divisor value and the run bit out to that generator.

The receiver waits for a high-to-low transition on the synchronized input and then samples every bit in the middle of its sixteen ticks. A frame whose stop bit is sampled low is dropped. A frame whose parity does not match is also dropped when parity is enabled. A good frame is placed in a single-entry receive holding register. Two status flags report a waiting received character and an occupied transmit holding register. Each direction has its own flush register that empties its holding entry. The interrupt-enable, guard-time and timeout words read as zero.

Top module: `uart_regcore`

## Requirements
- R1: After reset, tx_out is high, and the control word, the status word and the receive data word all read as zero.
- R2: Word indices are: 0 divisor (read/write, low 16 bits, also driven on baud_value), 1 transmit data (write only, reads zero), 2 receive data, 3 control, 5 status, 8 transmit flush, 9 receive flush. Indices 4, 6 and 7 read zero.
- R3: A transmitted frame is a low start bit, 8 data bits with the least significant bit first, then an odd parity bit only when control bit 5 is set, then a high stop bit. Each bit lasts 16 ticks. The parity bit makes the count of ones over data and parity odd.
- R4: Status bit 9 is 1 while the transmit holding entry is occupied. A write to index 1 while it is set is discarded, so the held character is the one sent.
- R5: With control bits 7 and 8 both set, a high-to-low transition on rx_in starts reception. Each bit is sampled at the middle of its 16 ticks. A good frame loads its byte and sets status bit 0.
- R6: A received frame whose stop bit is sampled low is discarded. When control bit 5 is set, a frame whose parity is not odd is also discarded. Status bit 0 stays 0 in both cases.
- R7: Reading index 2 returns the received byte in bits 7:0 with upper bits zero, and clears status bit 0.
- R8: Writing a word with bit 0 set to index 8 empties the transmit holding entry, so status bit 9 clears and that character is never sent. Doing the same to index 9 clears status bit 0.
- R9: While control bit 7 is 0, tx_out stays high, the transmit holding entry is not consumed and the receiver ignores rx_in. While control bit 8 is 0, the receiver ignores rx_in.
- R10: The control word stores only bits 0 to 5, 7 and 8. Its other bits read zero. Bit 7 is driven on baud_run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_16x | input | 1 | One-cycle pulse at 16 times the bit rate |
| reg_addr | input | 4 | Word index of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; a read of index 2 consumes the received byte |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| rx_in | input | 1 | Serial receive line |
| tx_out | output | 1 | Serial transmit line, idle high |
| baud_value | output | 16 | Stored divisor for the external tick generator |
| baud_run | output | 1 | Control bit 7, enables the external tick generator |

## Verification
If the transmit bit counter or tick counter goes wrong, the effect appears on tx_out within one bit time: bits shift out of place, the parity bit is missing or extra, or the stop bit is never reached, and mid-bit sampling of the line catches this. If the receive sampler goes wrong, the next frame ends with the wrong byte at index 2, or with status bit 0 set or clear when it should not be, within a few cycles after the stop bit. Faults in the holding flags show on status bits 0 and 9 on the read that follows the action, because each write, flush and read is followed by a status read.

// File: rtl/uart_regcore_pkg.sv
`timescale 1ns/1ps
package uart_regcore_pkg;
   // word indices of the register bank
   localparam int IDX_BAUD  = 0;
   localparam int IDX_TXD   = 1;
   localparam int IDX_RXD   = 2;
   localparam int IDX_CTRL  = 3;
   localparam int IDX_IEN   = 4;
   localparam int IDX_STAT  = 5;
   localparam int IDX_GUARD = 6;
   localparam int IDX_TMO   = 7;
   localparam int IDX_TXFL  = 8;
   localparam int IDX_RXFL  = 9;

   // control and status bit positions
   localparam int CB_PAR  = 5;
   localparam int CB_RUN  = 7;
   localparam int CB_RXEN = 8;
   localparam logic [31:0] CTRL_MASK = 32'h0000_01BF;
   localparam int SB_RXF = 0;
   localparam int SB_TXF = 9;

   typedef struct packed {
      logic run;
      logic rx_en;
      logic par_odd;
   } ctrl_t;
endpackage

// File: rtl/uart_tx_shifter.sv
`timescale 1ns/1ps
module uart_tx_shifter #(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              tick,
   input  logic              par_en,
   input  logic              hold_valid,
   input  logic [DATA_W-1:0] hold_data,
   output logic              load,
   output logic              tx_out
);
   localparam int CW = $clog2(OVS);
   localparam int FW = DATA_W + 3;
   localparam int IW = $clog2(FW + 1);

   logic          busy;
   logic [FW-1:0] sh;
   logic [CW-1:0] tcnt;
   logic [IW-1:0] bidx;
   logic [IW-1:0] last_idx;
   logic [FW-1:0] frame;

   assign last_idx = par_en ? IW'(FW - 1) : IW'(FW - 2);
   assign frame    = par_en ? {1'b1, ~^hold_data, hold_data, 1'b0}
                            : {2'b11, hold_data, 1'b0};
   assign load     = run && !busy && hold_valid;
   assign tx_out   = busy ? sh[0] : 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         busy <= 1'b0;
         sh   <= '1;
         tcnt <= '0;
         bidx <= '0;
      end else if (load) begin
         busy <= 1'b1;
         sh   <= frame;
         tcnt <= '0;
         bidx <= '0;
      end else if (busy && tick) begin
         if (tcnt == CW'(OVS - 1)) begin
            tcnt <= '0;
            if (bidx == last_idx) begin
               busy <= 1'b0;
            end else begin
               sh   <= {1'b1, sh[FW-1:1]};
               bidx <= bidx + 1'b1;
            end
         end else begin
            tcnt <= tcnt + 1'b1;
         end
      end
   end

   // R3
   tx_bidx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (bidx <= IW'(FW - 1)));
endmodule

// File: rtl/uart_rx_sampler.sv
`timescale 1ns/1ps
module uart_rx_sampler #(
   parameter int DATA_W      = 8,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              tick,
   input  logic              par_en,
   input  logic              rx_in,
   output logic              done,
   output logic [DATA_W-1:0] data
);
   localparam int CW  = $clog2(OVS);
   localparam int IW  = $clog2(DATA_W + 3);
   localparam int MID = OVS / 2 - 1;

   logic [SYNC_STAGES:0] chain;
   logic                 line;

   assign chain[0] = rx_in;
   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk) begin
         if (!rst_n) chain[g+1] <= 1'b1;
         else        chain[g+1] <= chain[g];
      end
   end
   assign line = chain[SYNC_STAGES];

   logic              busy;
   logic              prev;
   logic              par_bit;
   logic [CW-1:0]     tcnt;
   logic [IW-1:0]     bidx;
   logic [DATA_W-1:0] shift;

   assign data = shift;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         prev    <= 1'b1;
         par_bit <= 1'b0;
         tcnt    <= '0;
         bidx    <= '0;
         shift   <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!enable) begin
            busy <= 1'b0;
            prev <= 1'b1;
            tcnt <= '0;
            bidx <= '0;
         end else if (tick) begin
            prev <= line;
            if (!busy) begin
               if (prev && !line) begin
                  busy <= 1'b1;
                  tcnt <= '0;
                  bidx <= '0;
               end
            end else begin
               tcnt <= tcnt + 1'b1;
               if (tcnt == CW'(MID)) begin
                  if (bidx == '0) begin
                     if (line) busy <= 1'b0;
                     else      bidx <= bidx + 1'b1;
                  end else if (bidx <= IW'(DATA_W)) begin
                     shift <= {line, shift[DATA_W-1:1]};
                     bidx  <= bidx + 1'b1;
                  end else if (par_en && bidx == IW'(DATA_W + 1)) begin
                     par_bit <= line;
                     bidx    <= bidx + 1'b1;
                  end else begin
                     busy <= 1'b0;
                     if (line && (!par_en || par_bit == ~^shift))
                        done <= 1'b1;
                  end
               end
            end
         end
      end
   end

   // R5
   rx_bidx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (bidx <= IW'(DATA_W + 2)));
   // R6
   rx_stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(line));
endmodule

// File: rtl/uart_regcore.sv
`timescale 1ns/1ps
module uart_regcore
   import uart_regcore_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int BAUD_W      = 16,
   parameter int DATA_W      = 8,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_16x,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              rx_in,
   output logic              tx_out,
   output logic [BAUD_W-1:0] baud_value,
   output logic              baud_run
);
   if (ADDR_W < 4)                            $error("ADDR_W must reach index 9");
   if (BAUD_W < 1 || BAUD_W > 32)             $error("BAUD_W out of range");
   if (DATA_W < 5 || DATA_W > 9)              $error("DATA_W out of range");
   if (OVS < 4 || (OVS & (OVS - 1)) != 0)     $error("OVS must be a power of two >= 4");
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4)    $error("SYNC_STAGES out of range");

   logic [BAUD_W-1:0] baud_q;
   logic [31:0]       ctrl_q;
   ctrl_t             ctrl;
   logic [DATA_W-1:0] tx_hold, rx_hold, rx_data;
   logic              tx_full, rx_full, tx_load, rx_done;
   logic              wr_baud, wr_txd, wr_ctrl, wr_txfl, wr_rxfl, rd_rxd;

   assign ctrl.run     = ctrl_q[CB_RUN];
   assign ctrl.rx_en   = ctrl_q[CB_RXEN];
   assign ctrl.par_odd = ctrl_q[CB_PAR];

   assign wr_baud = reg_wr && reg_addr == ADDR_W'(IDX_BAUD);
   assign wr_txd  = reg_wr && reg_addr == ADDR_W'(IDX_TXD);
   assign wr_ctrl = reg_wr && reg_addr == ADDR_W'(IDX_CTRL);
   assign wr_txfl = reg_wr && reg_addr == ADDR_W'(IDX_TXFL) && reg_wdata[0];
   assign wr_rxfl = reg_wr && reg_addr == ADDR_W'(IDX_RXFL) && reg_wdata[0];
   assign rd_rxd  = reg_rd && reg_addr == ADDR_W'(IDX_RXD);

   assign baud_value = baud_q;
   assign baud_run   = ctrl.run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         baud_q  <= '0;
         ctrl_q  <= '0;
         tx_hold <= '0;
         tx_full <= 1'b0;
         rx_hold <= '0;
         rx_full <= 1'b0;
      end else begin
         if (wr_baud) baud_q <= reg_wdata[BAUD_W-1:0];
         if (wr_ctrl) ctrl_q <= reg_wdata & CTRL_MASK;

         if (wr_txfl || tx_load) begin
            tx_full <= 1'b0;
         end else if (wr_txd && !tx_full) begin
            tx_hold <= reg_wdata[DATA_W-1:0];
            tx_full <= 1'b1;
         end

         if (rx_done) begin
            rx_hold <= rx_data;
            rx_full <= 1'b1;
         end else if (wr_rxfl || rd_rxd) begin
            rx_full <= 1'b0;
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_W'(IDX_BAUD):  reg_rdata[BAUD_W-1:0] = baud_q;
         ADDR_W'(IDX_RXD):   reg_rdata[DATA_W-1:0] = rx_hold;
         ADDR_W'(IDX_CTRL):  reg_rdata = ctrl_q;
         ADDR_W'(IDX_STAT): begin
            reg_rdata[SB_RXF] = rx_full;
            reg_rdata[SB_TXF] = tx_full;
         end
         ADDR_W'(IDX_IEN), ADDR_W'(IDX_GUARD), ADDR_W'(IDX_TMO): reg_rdata = '0;
         default: reg_rdata = '0;
      endcase
   end

   uart_tx_shifter #(.DATA_W(DATA_W), .OVS(OVS)) tx_i (
      .clk(clk), .rst_n(rst_n), .run(ctrl.run), .tick(tick_16x),
      .par_en(ctrl.par_odd), .hold_valid(tx_full), .hold_data(tx_hold),
      .load(tx_load), .tx_out(tx_out));

   uart_rx_sampler #(.DATA_W(DATA_W), .OVS(OVS), .SYNC_STAGES(SYNC_STAGES)) rx_i (
      .clk(clk), .rst_n(rst_n), .enable(ctrl.run && ctrl.rx_en), .tick(tick_16x),
      .par_en(ctrl.par_odd), .rx_in(rx_in), .done(rx_done), .data(rx_data));

   // R4
   tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_txd && tx_full && !tx_load) |=> (tx_full && tx_hold == $past(tx_hold)));
   // R5
   rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |=> rx_full);
   // R7
   rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_rxd && !rx_done) |=> !rx_full);
   // R8
   tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_txfl |=> !tx_full);
   // R9
   idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.run |=> tx_out);
endmodule

// File: tb/uart_regcore_tb_top.sv
`timescale 1ns/1ps
module uart_regcore_tb_top;
   localparam int BITC = 64;   // clocks per bit: 16 ticks x 4 clocks
   localparam logic [31:0] CTL_BASE = 32'h09;   // 8-bit frames, one stop bit
   localparam logic [31:0] CTL_RUN  = 32'h80;
   localparam logic [31:0] CTL_RXEN = 32'h100;
   localparam logic [31:0] CTL_PAR  = 32'h20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_16x = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        rx_in = 1'b1;
   logic        tx_out;
   logic [15:0] baud_value;
   logic        baud_run;

   int n_chk = 0;
   int n_bad = 0;
   int tdiv = 0;

   always #5 clk = ~clk;

   always @(negedge clk) begin
      tdiv     <= (tdiv == 3) ? 0 : tdiv + 1;
      tick_16x <= (tdiv == 3);
   end

   uart_regcore dut_i (
      .clk(clk), .rst_n(rst_n), .tick_16x(tick_16x), .reg_addr(reg_addr),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .rx_in(rx_in), .tx_out(tx_out), .baud_value(baud_value), .baud_run(baud_run));

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   // capture one frame from tx_out; sample in the middle of each bit
   task automatic grab_tx(input bit par, output logic [7:0] d, output logic p,
                          output logic st, output bit seen);
      int w = 0;
      seen = 1'b0; d = '0; p = 1'b0; st = 1'b0;
      while (tx_out && w < 3000) begin @(negedge clk); w++; end
      if (tx_out) return;
      seen = 1'b1;
      repeat (BITC / 2) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         repeat (BITC) @(negedge clk);
         d[i] = tx_out;
      end
      if (par) begin repeat (BITC) @(negedge clk); p = tx_out; end
      repeat (BITC) @(negedge clk);
      st = tx_out;
      repeat (BITC) @(negedge clk);
   endtask

   task automatic drive_rx(input logic [7:0] d, input bit par, input bit flip, input logic stopv);
      @(negedge clk);
      rx_in = 1'b0; repeat (BITC) @(negedge clk);
      for (int i = 0; i < 8; i++) begin rx_in = d[i]; repeat (BITC) @(negedge clk); end
      if (par) begin rx_in = (~^d) ^ flip; repeat (BITC) @(negedge clk); end
      rx_in = stopv; repeat (BITC) @(negedge clk);
      rx_in = 1'b1;  repeat (BITC) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      chk(tx_out === 1'b1, "R1 idle line", {31'b0, tx_out}, 32'h1);
      rd_reg(4'd3, v); chk(v === 32'h0, "R1 control reset", v, 32'h0);
      rd_reg(4'd5, v); chk(v === 32'h0, "R1 status reset", v, 32'h0);
      rd_reg(4'd2, v); chk(v === 32'h0, "R1 rx data reset", v, 32'h0);
   endtask

   task automatic t_map();
      logic [31:0] v;
      wr_reg(4'd0, 32'h1234_ABCD);
      rd_reg(4'd0, v); chk(v === 32'h0000_ABCD, "R2 divisor readback", v, 32'hABCD);
      chk(baud_value === 16'hABCD, "R2 divisor port", {16'b0, baud_value}, 32'hABCD);
      for (int a = 4; a <= 7; a++) begin
         if (a == 5) continue;
         wr_reg(4'(a), 32'hFFFF_FFFF);
         rd_reg(4'(a), v); chk(v === 32'h0, "R2 zero word", v, 32'h0);
      end
      rd_reg(4'd1, v); chk(v === 32'h0, "R2 tx data reads zero", v, 32'h0);
      wr_reg(4'd3, 32'hFFFF_FFFF);
      rd_reg(4'd3, v); chk(v === 32'h0000_01BF, "R10 control mask", v, 32'h1BF);
      chk(baud_run === 1'b1, "R10 run port", {31'b0, baud_run}, 32'h1);
      wr_reg(4'd3, 32'h0);
   endtask

   task automatic t_hold();
      logic [31:0] v; logic [7:0] d; logic p, st; bit seen;
      wr_reg(4'd3, CTL_BASE);
      wr_reg(4'd1, 32'h5A);
      rd_reg(4'd5, v); chk(v[9] === 1'b1, "R4 tx full flag", v, 32'h200);
      wr_reg(4'd1, 32'hC3);
      repeat (300) @(negedge clk);
      chk(tx_out === 1'b1, "R9 no send while stopped", {31'b0, tx_out}, 32'h1);
      rd_reg(4'd5, v); chk(v[9] === 1'b1, "R9 holding kept while stopped", v, 32'h200);
      wr_reg(4'd3, CTL_BASE | CTL_RUN);
      grab_tx(1'b0, d, p, st, seen);
      chk(seen && d === 8'h5A, "R4 first char kept", {24'b0, d}, 32'h5A);
      rd_reg(4'd5, v); chk(v[9] === 1'b0, "R4 tx empty after send", v, 32'h0);
   endtask

   task automatic t_tx(input logic [7:0] c, input bit par);
      logic [7:0] d; logic p, st; bit seen;
      wr_reg(4'd3, CTL_BASE | CTL_RUN | (par ? CTL_PAR : 32'h0));
      wr_reg(4'd1, {24'b0, c});
      grab_tx(par, d, p, st, seen);
      chk(seen && d === c, "R3 tx data bits", {24'b0, d}, {24'b0, c});
      if (par) chk(p === ~^c, "R3 tx odd parity", {31'b0, p}, {31'b0, ~^c});
      chk(st === 1'b1, "R3 tx stop bit", {31'b0, st}, 32'h1);
   endtask

   task automatic t_rx(input logic [7:0] c, input bit par, input bit flip,
                       input logic stopv, input bit good, input logic [31:0] ctl);
      logic [31:0] v;
      wr_reg(4'd3, ctl);
      drive_rx(c, par, flip, stopv);
      rd_reg(4'd5, v);
      if (good) begin
         chk(v[0] === 1'b1, "R5 rx full flag", v, 32'h1);
         rd_reg(4'd2, v); chk(v === {24'b0, c}, "R7 rx byte", v, {24'b0, c});
         rd_reg(4'd5, v); chk(v[0] === 1'b0, "R7 read clears flag", v, 32'h0);
      end else begin
         chk(v[0] === 1'b0, "R6 R9 frame dropped", v, 32'h0);
      end
   endtask

   task automatic t_flush();
      logic [31:0] v; bit quiet = 1'b1;
      wr_reg(4'd3, CTL_BASE | CTL_RUN | CTL_RXEN);
      drive_rx(8'h42, 1'b0, 1'b0, 1'b1);
      rd_reg(4'd5, v); chk(v[0] === 1'b1, "R8 rx loaded before flush", v, 32'h1);
      wr_reg(4'd9, 32'h1);
      rd_reg(4'd5, v); chk(v[0] === 1'b0, "R8 rx flush", v, 32'h0);
      wr_reg(4'd3, CTL_BASE);
      wr_reg(4'd1, 32'h77);
      wr_reg(4'd8, 32'h1);
      rd_reg(4'd5, v); chk(v[9] === 1'b0, "R8 tx flush", v, 32'h0);
      wr_reg(4'd3, CTL_BASE | CTL_RUN);
      repeat (900) begin @(negedge clk); if (!tx_out) quiet = 1'b0; end
      chk(quiet, "R8 flushed char not sent", {31'b0, quiet}, 32'h1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_map();
      t_hold();
      t_tx(8'hA5, 1'b0);
      t_tx(8'h01, 1'b0);
      t_tx(8'h3C, 1'b1);
      t_tx(8'h07, 1'b1);
      t_rx(8'h96, 1'b0, 1'b0, 1'b1, 1'b1, CTL_BASE | CTL_RUN | CTL_RXEN);
      t_rx(8'h3D, 1'b1, 1'b0, 1'b1, 1'b1, CTL_BASE | CTL_RUN | CTL_RXEN | CTL_PAR);
      t_rx(8'h3D, 1'b1, 1'b1, 1'b1, 1'b0, CTL_BASE | CTL_RUN | CTL_RXEN | CTL_PAR); // R6 parity
      t_rx(8'hE1, 1'b0, 1'b0, 1'b0, 1'b0, CTL_BASE | CTL_RUN | CTL_RXEN);         // R6 low stop
      t_rx(8'h55, 1'b0, 1'b0, 1'b1, 1'b0, CTL_BASE | CTL_RUN);                    // R9 rx disabled
      t_rx(8'h55, 1'b0, 1'b0, 1'b1, 1'b0, CTL_BASE | CTL_RXEN);                   // R9 not running
      t_flush();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule